// File: doc/BRIEF.md
# Four-Word Shared-Bus Register File

This block is a small synchronous memory of four 8-bit words. A single port reaches it through a 2-bit address, one read/write select and an 8-bit data bus that the memory and an outside agent both drive. When the select is high, the memory puts the addressed word on the bus. When the select is low, the memory lets go of the bus and stores what the outside agent drives there on the next rising clock edge.

Each word is a clocked register with its own load enable. Only the addressed word's enable is raised during a write. The read path is combinational from the address, so a read needs no clock edge. A synchronous clear input sets every word to zero and wins over a write in the same cycle. The active-high synchronous reset has the same effect.

Top module: `spmem_quad`

## Requirements
- R1: The memory holds four 8-bit words, and the 2-bit address selects word 0 to 3.
- R2: While `rd_nwr` is 1, the bus carries the addressed word in the same cycle, with no clock edge needed, and follows an address change within that cycle.
- R3: While `rd_nwr` is 0 and `clr` is 0, the value on the bus at a rising clock edge is stored into the addressed word.
- R4: While `rd_nwr` is 0, the memory drives no bit of the bus: every bit reads high impedance when no outside agent drives it, and an outside value is seen on the bus without X.
- R5: When `clr` is 1 at a rising edge, all four words become zero, even if a write is requested in that cycle.
- R6: When `rst` is 1 at a rising edge, all four words become zero, so a read of any address after reset returns 0x00.
- R7: A write changes only the addressed word. The other three words keep their values.
- R8: A clear applied while `rd_nwr` is 1 also zeroes every word, and a later read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, zeroes all words |
| clr | input | 1 | Synchronous clear, active high, zeroes all words and overrides a write |
| rd_nwr | input | 1 | Access select: 1 = read (memory drives the bus), 0 = write (memory releases the bus) |
| addr | input | 2 | Word address |
| data | inout | 8 | Shared bidirectional data bus |

## Verification
The bench goes after bus ownership first. It releases the bus from both sides during a write-mode cycle and expects every bit to float; a design that kept its drivers on would show the stored word or X there instead of Z. It writes a distinct value to each word and reads them all back; a decoder that raised more than one enable would overwrite a neighbour, and one that dropped an enable would leave an old value. It asserts clear together with a write, which catches a design that lets the write win. It also moves the address inside a single read cycle, which shows whether the read path is registered.

// File: rtl/spmem_pkg.sv
package spmem_pkg;

    localparam int DEF_WORD_W = 8;
    localparam int DEF_DEPTH  = 4;

    // Meaning of the single access-select pin.
    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } access_e;

    // One access as presented at the port in a given cycle.
    typedef struct packed {
        access_e mode;
        logic    clear;
    } access_t;

    function automatic access_t make_access(logic sel, logic clr_in);
        access_t a;
        a.mode  = access_e'(sel);
        a.clear = clr_in;
        return a;
    endfunction

    // A write commits only when it is not overridden by a clear.
    function automatic logic write_commits(access_t a);
        return (a.mode == ACC_WRITE) && !a.clear;
    endfunction

    function automatic logic bus_owned(access_t a);
        return a.mode == ACC_READ;
    endfunction

endpackage

// File: rtl/spmem_word.sv
module spmem_word #(
    parameter int WORD_W = spmem_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ld,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

    // R5: a clear leaves the word at zero on the next cycle.
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

    // R7: a word whose enable is low keeps its value.
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld && !clr) |=> $stable(q));

endmodule

// File: rtl/spmem_wdec.sv
module spmem_wdec #(
    parameter int DEPTH  = spmem_pkg::DEF_DEPTH,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  ld
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_sel
        assign ld[i] = wr_en && (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/spmem_rmux.sv
module spmem_rmux #(
    parameter int WORD_W = spmem_pkg::DEF_WORD_W,
    parameter int DEPTH  = spmem_pkg::DEF_DEPTH,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][WORD_W-1:0] words,
    input  logic [ADDR_W-1:0]            addr,
    output logic [WORD_W-1:0]            y
);

    always_comb begin
        y = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == ADDR_W'(i)) begin
                y = words[i];
            end
        end
    end

endmodule

// File: rtl/spmem_quad.sv
module spmem_quad #(
    parameter int WORD_W = spmem_pkg::DEF_WORD_W,
    parameter int DEPTH  = spmem_pkg::DEF_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [WORD_W-1:0] data
);
    import spmem_pkg::*;

    access_t                      acc;
    logic                         wr_en;
    logic                         drive_en;
    logic [DEPTH-1:0]             ld_vec;
    logic [DEPTH-1:0][WORD_W-1:0] word_q;
    logic [WORD_W-1:0]            rd_word;

    assign acc      = make_access(rd_nwr, clr);
    assign wr_en    = write_commits(acc);
    assign drive_en = bus_owned(acc);

    spmem_wdec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wdec (
        .wr_en (wr_en),
        .addr  (addr),
        .ld    (ld_vec)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        spmem_word #(.WORD_W(WORD_W)) u_word (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .ld  (ld_vec[i]),
            .d   (data),
            .q   (word_q[i])
        );
    end

    spmem_rmux #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rmux (
        .words (word_q),
        .addr  (addr),
        .y     (rd_word)
    );

    // R4: drivers are off in write mode.
    assign data = drive_en ? rd_word : {WORD_W{1'bz}};

    // R3: a committed write lands in the addressed word.
    a_r3_commit: assert property (@(posedge clk) disable iff (rst)
        (!rd_nwr && !clr) |=> (word_q[$past(addr)] == $past(data)));

    // R2: in read mode the bus carries the addressed word.
    a_r2_read_bus: assert property (@(posedge clk) disable iff (rst)
        rd_nwr |-> (data == word_q[addr]));

endmodule

// File: tb/spmem_quad_tb.sv
module spmem_quad_tb;

    localparam int W = 8;
    localparam int N = 4;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0;
    logic         rd_nwr = 1'b1;
    logic [1:0]   addr = '0;
    logic         tb_drv_en = 1'b0;
    logic [W-1:0] tb_drv = '0;
    wire  [W-1:0] data;

    logic [W-1:0] model [N];
    item_t        sb_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    assign data = tb_drv_en ? tb_drv : {W{1'bz}};

    always #10 clk = ~clk;  // 50 MHz

    spmem_quad u_dut (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .rd_nwr (rd_nwr),
        .addr   (addr),
        .data   (data)
    );

    // Monitor: compare the bus against queued expectations away from the edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (data !== it.exp) begin
                n_fail++;
                $display("FAIL %s: bus=%b expected=%b", it.tag, data, it.exp);
            end
        end
    end

    task automatic do_read(input logic [1:0] a, input string tag);
        @(posedge clk); #2;
        rd_nwr = 1'b1; tb_drv_en = 1'b0; addr = a;
        sb_q.push_back('{model[a], tag});
    endtask

    // R2: two reads inside one cycle, checked directly.
    task automatic read_twice_same_cycle(input logic [1:0] a0, input logic [1:0] a1);
        @(posedge clk); #2;
        rd_nwr = 1'b1; tb_drv_en = 1'b0; addr = a0;
        #2;
        n_checks++;
        if (data !== model[a0]) begin
            n_fail++;
            $display("FAIL R2: bus=%h expected=%h", data, model[a0]);
        end
        addr = a1;
        #2;
        n_checks++;
        if (data !== model[a1]) begin
            n_fail++;
            $display("FAIL R2: bus=%h expected=%h", data, model[a1]);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [W-1:0] v);
        @(posedge clk); #2;
        rd_nwr = 1'b0; addr = a; tb_drv = v; tb_drv_en = 1'b1;
        sb_q.push_back('{v, "R4"});  // outside value seen without contention
        @(posedge clk); #2;
        model[a] = v;                // R3
        rd_nwr = 1'b1; tb_drv_en = 1'b0;
    endtask

    // R4: both sides released; every bit must float. Restored before the edge.
    task automatic check_release(input logic [1:0] a);
        @(posedge clk); #2;
        rd_nwr = 1'b0; addr = a; tb_drv_en = 1'b0;
        sb_q.push_back('{{W{1'bz}}, "R4"});
        @(negedge clk); #2;
        rd_nwr = 1'b1;
    endtask

    task automatic do_clear(input logic with_write);
        @(posedge clk); #2;
        clr = 1'b1;
        if (with_write) begin
            rd_nwr = 1'b0; addr = 2'd2; tb_drv = 8'h77; tb_drv_en = 1'b1;
        end else begin
            rd_nwr = 1'b1; tb_drv_en = 1'b0;
        end
        @(posedge clk); #2;
        clr = 1'b0; rd_nwr = 1'b1; tb_drv_en = 1'b0;
        for (int i = 0; i < N; i++) model[i] = '0;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < N; i++) do_read(2'(i), tag);
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        read_all("R6");                       // reset state

        for (int i = 0; i < N; i++) do_write(2'(i), 8'(8'h11 * (i + 1)));
        read_all("R1");                       // four distinct words
        read_all("R3");

        do_write(2'd1, 8'hA5);                // R7: neighbours unchanged
        read_all("R7");

        check_release(2'd0);
        check_release(2'd3);

        read_twice_same_cycle(2'd1, 2'd3);

        do_write(2'd0, 8'hFF);
        do_write(2'd3, 8'h00);
        do_write(2'd2, 8'h5A);
        read_all("R3");

        do_clear(1'b1);                       // R5: clear beats write
        read_all("R5");

        for (int i = 0; i < N; i++) do_write(2'(i), 8'(8'hC0 + i));
        read_all("R7");
        do_clear(1'b0);                       // R8: clear in read mode
        read_all("R8");

        do_write(2'd2, 8'h3C);
        do_write(2'd0, 8'h81);
        @(posedge clk); #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        for (int i = 0; i < N; i++) model[i] = '0;
        read_all("R6");

        @(posedge clk);
        @(negedge clk); #1;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule